// File: doc/BRIEF.md
# Send/Receive Rendezvous Matcher

This block sits at the receiving end of a three-phase message transfer. Two kinds of event reach it. A remote sender announces a message with a small fixed-format notice that gives the sender's identity, a tag and a length. Local software posts a receive that names the sender it expects, a tag and the address where the data should land. The block keeps every unmatched event in a small ordered table. Whichever event arrives second finds its partner there, and the block then emits a fixed-format clearance reply to the sender. That reply carries the landing address and the announced length.

After the reply goes out, the block accepts the variable-length data stream that the sender is now allowed to push. It writes each beat to consecutive addresses, starting at the posted address, and raises a completion pulse with the final beat. Only one data transfer can be open at a time. While it is open, arrivals that would match are held off, and arrivals that do not match can still be recorded.

Top module: `rdv_match_engine`

## Requirements
- R1: After reset the table is empty, `rtr_valid` and `data_ready` are low, and both `rts_ready` and `post_ready` are high.
- R2: A send notice that finds no posted receive with equal source and tag is stored and produces no reply.
- R3: A posted receive that finds a stored send notice with equal source and tag produces a reply in the next cycle. The reply carries that source and tag, the posted address and the stored length.
- R4: A send notice that finds a stored receive with equal source and tag produces a reply in the next cycle. The reply carries the receive's address and the notice's length.
- R5: A match needs equal source and equal tag between entries of opposite kinds. Two entries of the same kind never match each other.
- R6: When several stored entries match an arrival, the one stored earliest is consumed.
- R7: A matched entry is removed in the same cycle the reply is launched, so a later arrival with the same key cannot match it again.
- R8: `data_ready` is low until a reply has been launched. Each accepted data beat then appears on `wr_valid`/`wr_addr`/`wr_data` in the same cycle, with the address rising by one per beat from the reply address.
- R9: The beat flagged `data_last` raises `done` in the same cycle, with the matched source and tag. `data_ready` is low in the following cycle.
- R10: When the table holds DEPTH entries, an arrival with no match is refused (ready low), while an arrival that matches is still accepted.
- R11: While a transfer is open, an arrival that would match is refused, and an arrival without a match is still stored.
- R12: If a send notice and a posted receive are offered in the same cycle, the send notice is taken and `post_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rts_valid | input | 1 | Send notice offered |
| rts_ready | output | 1 | Send notice accepted this cycle |
| rts_src | input | SRC_W | Sender identity of the notice |
| rts_tag | input | TAG_W | Message tag of the notice |
| rts_len | input | LEN_W | Announced message length in beats |
| post_valid | input | 1 | Local receive offered |
| post_ready | output | 1 | Local receive accepted this cycle |
| post_src | input | SRC_W | Expected sender |
| post_tag | input | TAG_W | Expected tag |
| post_addr | input | ADDR_W | Landing address for the data |
| rtr_valid | output | 1 | One-cycle clearance reply |
| rtr_src | output | SRC_W | Sender the reply goes to |
| rtr_tag | output | TAG_W | Tag of the cleared message |
| rtr_addr | output | ADDR_W | Landing address granted |
| rtr_len | output | LEN_W | Length taken from the send notice |
| data_valid | input | 1 | Data beat present |
| data_last | input | 1 | Beat is the final one |
| data_in | input | DATA_W | Beat payload |
| data_ready | output | 1 | A transfer is open and beats are taken |
| wr_valid | output | 1 | Beat write strobe |
| wr_addr | output | ADDR_W | Beat write address |
| wr_data | output | DATA_W | Beat write data |
| done | output | 1 | Receive complete, one cycle |
| done_src | output | SRC_W | Sender of the completed message |
| done_tag | output | TAG_W | Tag of the completed message |

## Verification
Both ready outputs are combinational on the offered event, so the bench reads them a quarter period after it drives the inputs and before the accepting edge. A reply is registered and appears in the cycle after the accepting edge. A scoreboard queue holds the expected replies, and a monitor sampling at the falling edge pops one entry for each reply it sees. The write strobe and `done` are combinational on the beat, so they are compared in the same cycle the beat is driven, and `data_ready` is checked low one cycle after the last beat.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
   typedef enum logic {
      KIND_SEND = 1'b0,
      KIND_RECV = 1'b1
   } kind_e;
endpackage

// File: rtl/rdv_first_hit.sv
module rdv_first_hit #(
   parameter int N = 8
) (
   input  logic [N-1:0]               hit_vec,
   output logic                       any,
   output logic [$clog2(N)-1:0]       idx
);
   localparam int IDX_W = $clog2(N);

   if (N < 2) begin : g_bad_n
      $error("rdv_first_hit: N must be at least 2");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rdv_table.sv
module rdv_table #(
   parameter int DEPTH  = 8,
   parameter int SRC_W  = 4,
   parameter int TAG_W  = 8,
   parameter int INFO_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SRC_W-1:0]           qa_src,
   input  logic [TAG_W-1:0]           qa_tag,
   output logic                       a_hit,
   output logic [$clog2(DEPTH)-1:0]   a_idx,
   output logic [INFO_W-1:0]          a_info,
   input  logic [SRC_W-1:0]           qb_src,
   input  logic [TAG_W-1:0]           qb_tag,
   output logic                       b_hit,
   output logic [$clog2(DEPTH)-1:0]   b_idx,
   output logic [INFO_W-1:0]          b_info,
   input  logic                       ins_en,
   input  rdv_pkg::kind_e             ins_kind,
   input  logic [SRC_W-1:0]           ins_src,
   input  logic [TAG_W-1:0]           ins_tag,
   input  logic [INFO_W-1:0]          ins_info,
   input  logic                       rm_en,
   input  logic [$clog2(DEPTH)-1:0]   rm_idx,
   output logic                       full
);
   import rdv_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("rdv_table: DEPTH must lie in 2..64");
   end

   logic [DEPTH-1:0]  ent_vld;
   kind_e             ent_kind [DEPTH];
   logic [SRC_W-1:0]  ent_src  [DEPTH];
   logic [TAG_W-1:0]  ent_tag  [DEPTH];
   logic [INFO_W-1:0] ent_info [DEPTH];
   logic [CNT_W-1:0]  cnt;

   logic [DEPTH-1:0]  hit_a_vec;
   logic [DEPTH-1:0]  hit_b_vec;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_a_vec[g] = ent_vld[g] && (ent_kind[g] == KIND_RECV)
                            && (ent_src[g] == qa_src) && (ent_tag[g] == qa_tag);
      assign hit_b_vec[g] = ent_vld[g] && (ent_kind[g] == KIND_SEND)
                            && (ent_src[g] == qb_src) && (ent_tag[g] == qb_tag);
   end

   rdv_first_hit #(.N(DEPTH)) u_pick_a (
      .hit_vec (hit_a_vec),
      .any     (a_hit),
      .idx     (a_idx)
   );

   rdv_first_hit #(.N(DEPTH)) u_pick_b (
      .hit_vec (hit_b_vec),
      .any     (b_hit),
      .idx     (b_idx)
   );

   assign a_info = ent_info[a_idx];
   assign b_info = ent_info[b_idx];
   assign full   = (cnt == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         ent_vld <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_kind[i] <= KIND_SEND;
            ent_src[i]  <= '0;
            ent_tag[i]  <= '0;
            ent_info[i] <= '0;
         end
      end else if (rm_en) begin
         cnt <= cnt - 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            if (IDX_W'(i) >= rm_idx) begin
               if (i == DEPTH - 1) begin
                  ent_vld[i] <= 1'b0;
               end else begin
                  ent_vld[i]  <= ent_vld[i+1];
                  ent_kind[i] <= ent_kind[i+1];
                  ent_src[i]  <= ent_src[i+1];
                  ent_tag[i]  <= ent_tag[i+1];
                  ent_info[i] <= ent_info[i+1];
               end
            end
         end
      end else if (ins_en && !full) begin
         cnt <= cnt + 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) == cnt) begin
               ent_vld[i]  <= 1'b1;
               ent_kind[i] <= ins_kind;
               ent_src[i]  <= ins_src;
               ent_tag[i]  <= ins_tag;
               ent_info[i] <= ins_info;
            end
         end
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !full);

   // R7
   rm_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rm_en |-> ent_vld[rm_idx]);

   // R7
   rm_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rm_en |=> (cnt == $past(cnt) - 1'b1));

   // R6
   packed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ent_vld) == int'(cnt));
endmodule

// File: rtl/rdv_xfer.sv
module rdv_xfer #(
   parameter int SRC_W  = 4,
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [SRC_W-1:0]   start_src,
   input  logic [TAG_W-1:0]   start_tag,
   input  logic [ADDR_W-1:0]  start_addr,
   input  logic               data_valid,
   input  logic               data_last,
   input  logic [DATA_W-1:0]  data_in,
   output logic               data_ready,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   output logic               done,
   output logic [SRC_W-1:0]   done_src,
   output logic [TAG_W-1:0]   done_tag,
   output logic               busy
);
   logic [ADDR_W-1:0] cur_addr;
   logic [SRC_W-1:0]  cur_src;
   logic [TAG_W-1:0]  cur_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur_addr <= '0;
         cur_src  <= '0;
         cur_tag  <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         cur_addr <= start_addr;
         cur_src  <= start_src;
         cur_tag  <= start_tag;
      end else if (data_valid && busy) begin
         cur_addr <= cur_addr + 1'b1;
         if (data_last) begin
            busy <= 1'b0;
         end
      end
   end

   assign data_ready = busy;
   assign wr_valid   = data_valid && busy;
   assign wr_addr    = cur_addr;
   assign wr_data    = data_in;
   assign done       = wr_valid && data_last;
   assign done_src   = cur_src;
   assign done_tag   = cur_tag;

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R9
   close_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: rtl/rdv_match_engine.sv
module rdv_match_engine #(
   parameter int DEPTH  = 8,
   parameter int SRC_W  = 4,
   parameter int TAG_W  = 8,
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rts_valid,
   output logic               rts_ready,
   input  logic [SRC_W-1:0]   rts_src,
   input  logic [TAG_W-1:0]   rts_tag,
   input  logic [LEN_W-1:0]   rts_len,
   input  logic               post_valid,
   output logic               post_ready,
   input  logic [SRC_W-1:0]   post_src,
   input  logic [TAG_W-1:0]   post_tag,
   input  logic [ADDR_W-1:0]  post_addr,
   output logic               rtr_valid,
   output logic [SRC_W-1:0]   rtr_src,
   output logic [TAG_W-1:0]   rtr_tag,
   output logic [ADDR_W-1:0]  rtr_addr,
   output logic [LEN_W-1:0]   rtr_len,
   input  logic               data_valid,
   input  logic               data_last,
   input  logic [DATA_W-1:0]  data_in,
   output logic               data_ready,
   output logic               wr_valid,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0]  wr_data,
   output logic               done,
   output logic [SRC_W-1:0]   done_src,
   output logic [TAG_W-1:0]   done_tag
);
   import rdv_pkg::*;

   localparam int IDX_W  = $clog2(DEPTH);
   localparam int INFO_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W;

   if (SRC_W < 1 || TAG_W < 1 || ADDR_W < 1 || LEN_W < 1 || DATA_W < 1) begin : g_bad_w
      $error("rdv_match_engine: all widths must be positive");
   end

   logic               a_hit, b_hit, tbl_full, xfer_busy;
   logic [IDX_W-1:0]   a_idx, b_idx;
   logic [INFO_W-1:0]  a_info, b_info;
   logic [INFO_W-1:0]  rts_info, post_info;
   logic               rts_fire, post_fire, match;
   logic               ins_en, rm_en;
   kind_e              ins_kind;
   logic [SRC_W-1:0]   ins_src;
   logic [TAG_W-1:0]   ins_tag;
   logic [INFO_W-1:0]  ins_info;
   logic [IDX_W-1:0]   rm_idx;
   logic [ADDR_W-1:0]  grant_addr;
   logic [LEN_W-1:0]   grant_len;

   if (ADDR_W == INFO_W) begin : g_addr_full
      assign post_info = post_addr;
   end else begin : g_addr_pad
      assign post_info = {{(INFO_W-ADDR_W){1'b0}}, post_addr};
   end

   if (LEN_W == INFO_W) begin : g_len_full
      assign rts_info = rts_len;
   end else begin : g_len_pad
      assign rts_info = {{(INFO_W-LEN_W){1'b0}}, rts_len};
   end

   rdv_table #(
      .DEPTH  (DEPTH),
      .SRC_W  (SRC_W),
      .TAG_W  (TAG_W),
      .INFO_W (INFO_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .qa_src   (rts_src),
      .qa_tag   (rts_tag),
      .a_hit    (a_hit),
      .a_idx    (a_idx),
      .a_info   (a_info),
      .qb_src   (post_src),
      .qb_tag   (post_tag),
      .b_hit    (b_hit),
      .b_idx    (b_idx),
      .b_info   (b_info),
      .ins_en   (ins_en),
      .ins_kind (ins_kind),
      .ins_src  (ins_src),
      .ins_tag  (ins_tag),
      .ins_info (ins_info),
      .rm_en    (rm_en),
      .rm_idx   (rm_idx),
      .full     (tbl_full)
   );

   assign rts_ready  = a_hit ? !xfer_busy : !tbl_full;
   assign post_ready = !rts_valid && (b_hit ? !xfer_busy : !tbl_full);
   assign rts_fire   = rts_valid && rts_ready;
   assign post_fire  = post_valid && post_ready;
   assign match      = (rts_fire && a_hit) || (post_fire && b_hit);

   assign rm_en    = match;
   assign rm_idx   = rts_fire ? a_idx : b_idx;
   assign ins_en   = (rts_fire && !a_hit) || (post_fire && !b_hit);
   assign ins_kind = rts_fire ? KIND_SEND : KIND_RECV;
   assign ins_src  = rts_fire ? rts_src : post_src;
   assign ins_tag  = rts_fire ? rts_tag : post_tag;
   assign ins_info = rts_fire ? rts_info : post_info;

   assign grant_addr = rts_fire ? a_info[ADDR_W-1:0] : post_addr;
   assign grant_len  = rts_fire ? rts_len : b_info[LEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rtr_valid <= 1'b0;
         rtr_src   <= '0;
         rtr_tag   <= '0;
         rtr_addr  <= '0;
         rtr_len   <= '0;
      end else begin
         rtr_valid <= match;
         if (match) begin
            rtr_src  <= ins_src;
            rtr_tag  <= ins_tag;
            rtr_addr <= grant_addr;
            rtr_len  <= grant_len;
         end
      end
   end

   rdv_xfer #(
      .SRC_W  (SRC_W),
      .TAG_W  (TAG_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_xfer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (match),
      .start_src  (ins_src),
      .start_tag  (ins_tag),
      .start_addr (grant_addr),
      .data_valid (data_valid),
      .data_last  (data_last),
      .data_in    (data_in),
      .data_ready (data_ready),
      .wr_valid   (wr_valid),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .done       (done),
      .done_src   (done_src),
      .done_tag   (done_tag),
      .busy       (xfer_busy)
   );

   // R12
   one_table_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ins_en, rm_en}));

   // R8
   reply_opens_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rtr_valid |-> xfer_busy);

   // R11
   held_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_busy && !(done)) |-> !rm_en);
endmodule

// File: tb/rdv_match_engine_tb_top.sv
module rdv_match_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q = CLK_PERIOD / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rts_valid = 1'b0, post_valid = 1'b0;
   logic        rts_ready, post_ready;
   logic [3:0]  rts_src = '0, post_src = '0;
   logic [7:0]  rts_tag = '0, post_tag = '0;
   logic [11:0] rts_len = '0;
   logic [15:0] post_addr = '0;
   logic        rtr_valid;
   logic [3:0]  rtr_src;
   logic [7:0]  rtr_tag;
   logic [15:0] rtr_addr;
   logic [11:0] rtr_len;
   logic        data_valid = 1'b0, data_last = 1'b0;
   logic [31:0] data_in = '0;
   logic        data_ready, wr_valid, done;
   logic [15:0] wr_addr;
   logic [31:0] wr_data;
   logic [3:0]  done_src;
   logic [7:0]  done_tag;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [3:0]  src;
      logic [7:0]  tag;
      logic [15:0] addr;
      logic [11:0] len;
   } reply_t;

   reply_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rdv_match_engine dut_i (
      .clk(clk), .rst_n(rst_n),
      .rts_valid(rts_valid), .rts_ready(rts_ready), .rts_src(rts_src),
      .rts_tag(rts_tag), .rts_len(rts_len),
      .post_valid(post_valid), .post_ready(post_ready), .post_src(post_src),
      .post_tag(post_tag), .post_addr(post_addr),
      .rtr_valid(rtr_valid), .rtr_src(rtr_src), .rtr_tag(rtr_tag),
      .rtr_addr(rtr_addr), .rtr_len(rtr_len),
      .data_valid(data_valid), .data_last(data_last), .data_in(data_in),
      .data_ready(data_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .done(done), .done_src(done_src), .done_tag(done_tag)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor: every reply must match the oldest expected one (R3, R4, R6)
   always @(negedge clk) begin
      if (rst_n && rtr_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "reply with none expected", {rtr_src, rtr_tag, rtr_addr, rtr_len}, 0);
         end else begin
            reply_t e;
            e = exp_q.pop_front();
            chk({rtr_src, rtr_tag, rtr_addr, rtr_len} == e, "R3/R4/R6", "reply fields",
                {rtr_src, rtr_tag, rtr_addr, rtr_len}, e);
         end
      end
   end

   task automatic offer_rts(input logic [3:0] s, input logic [7:0] t, input logic [11:0] l,
                            input bit exp_rdy, input bit exp_hit, input logic [15:0] exp_addr,
                            input string req);
      @(negedge clk);
      rts_valid = 1'b1; rts_src = s; rts_tag = t; rts_len = l;
      #Q;
      chk(rts_ready == exp_rdy, req, "rts_ready", rts_ready, exp_rdy);
      if (rts_ready && exp_hit) exp_q.push_back({s, t, exp_addr, l});
      @(posedge clk);
      #1 rts_valid = 1'b0;
   endtask

   task automatic offer_post(input logic [3:0] s, input logic [7:0] t, input logic [15:0] a,
                             input bit exp_rdy, input bit exp_hit, input logic [11:0] exp_len,
                             input string req);
      @(negedge clk);
      post_valid = 1'b1; post_src = s; post_tag = t; post_addr = a;
      #Q;
      chk(post_ready == exp_rdy, req, "post_ready", post_ready, exp_rdy);
      if (post_ready && exp_hit) exp_q.push_back({s, t, a, exp_len});
      @(posedge clk);
      #1 post_valid = 1'b0;
   endtask

   task automatic stream(input int n, input logic [15:0] base, input logic [3:0] s,
                         input logic [7:0] t);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         data_valid = 1'b1; data_in = 32'hA000_0000 + 32'(base) + 32'(i);
         data_last = (i == n - 1);
         #Q;
         // R8
         chk(wr_valid && data_ready, "R8", "beat taken", {wr_valid, data_ready}, 2'b11);
         chk(wr_addr == base + 16'(i), "R8", "beat address", wr_addr, base + 16'(i));
         chk(wr_data == data_in, "R8", "beat data", wr_data, data_in);
         // R9
         chk(done == (i == n - 1), "R9", "done timing", done, (i == n - 1));
         if (i == n - 1)
            chk({done_src, done_tag} == {s, t}, "R9", "done id", {done_src, done_tag}, {s, t});
         @(posedge clk);
         #1 data_valid = 1'b0; data_last = 1'b0;
      end
      @(negedge clk);
      #Q;
      // R9
      chk(data_ready == 1'b0, "R9", "ready low after last", data_ready, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL R1 watchdog expired: act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, and R8: a beat while idle is refused
      data_valid = 1'b1; data_last = 1'b1;
      #Q;
      chk(rts_ready && post_ready, "R1", "both ready", {rts_ready, post_ready}, 2'b11);
      chk(!rtr_valid, "R1", "no reply", rtr_valid, 0);
      chk(!data_ready && !wr_valid, "R8", "idle beat refused", {data_ready, wr_valid}, 0);
      @(posedge clk);
      #1 data_valid = 1'b0; data_last = 1'b0;

      // R2: notice stored, no reply; R3: local receive finds it
      offer_rts(4'd1, 8'd5, 12'd4, 1, 0, '0, "R2");
      offer_post(4'd1, 8'd5, 16'h0100, 1, 1, 12'd4, "R3");
      // R11: open transfer, non-matching stored, matching refused
      offer_rts(4'd9, 8'd9, 12'd2, 1, 0, '0, "R11");
      offer_post(4'd9, 8'd9, 16'h0900, 0, 0, '0, "R11");
      stream(4, 16'h0100, 4'd1, 8'd5);
      offer_post(4'd9, 8'd9, 16'h0900, 1, 1, 12'd2, "R11");
      stream(2, 16'h0900, 4'd9, 8'd9);

      // R7: consumed notice does not match again; R4: notice finds receive
      offer_post(4'd1, 8'd5, 16'h0180, 1, 0, '0, "R7");
      offer_rts(4'd1, 8'd5, 12'd1, 1, 1, 16'h0180, "R4");
      stream(1, 16'h0180, 4'd1, 8'd5);

      // R6: oldest receive wins
      offer_post(4'd2, 8'd7, 16'h0200, 1, 0, '0, "R6");
      offer_post(4'd2, 8'd7, 16'h0300, 1, 0, '0, "R6");
      offer_rts(4'd2, 8'd7, 12'd2, 1, 1, 16'h0200, "R6");
      stream(2, 16'h0200, 4'd2, 8'd7);
      offer_rts(4'd2, 8'd7, 12'd1, 1, 1, 16'h0300, "R6");
      stream(1, 16'h0300, 4'd2, 8'd7);

      // R5: same kind never matches, partial key never matches
      offer_rts(4'd3, 8'd9, 12'd5, 1, 0, '0, "R5");
      offer_rts(4'd3, 8'd9, 12'd6, 1, 0, '0, "R5");
      offer_post(4'd3, 8'd8, 16'h0400, 1, 0, '0, "R5");
      offer_post(4'd4, 8'd9, 16'h0480, 1, 0, '0, "R5");
      offer_post(4'd3, 8'd9, 16'h0500, 1, 1, 12'd5, "R5");
      stream(5, 16'h0500, 4'd3, 8'd9);

      // R12: simultaneous offer, notice goes first
      @(negedge clk);
      rts_valid = 1'b1; rts_src = 4'd5; rts_tag = 8'd1; rts_len = 12'd3;
      post_valid = 1'b1; post_src = 4'd5; post_tag = 8'd1; post_addr = 16'h0600;
      #Q;
      chk(rts_ready == 1'b1, "R12", "notice taken", rts_ready, 1);
      chk(post_ready == 1'b0, "R12", "receive held", post_ready, 0);
      @(posedge clk);
      #1 rts_valid = 1'b0;
      @(negedge clk);
      #Q;
      chk(post_ready == 1'b1, "R12", "receive taken next", post_ready, 1);
      exp_q.push_back({4'd5, 8'd1, 16'h0600, 12'd3});
      @(posedge clk);
      #1 post_valid = 1'b0;
      stream(3, 16'h0600, 4'd5, 8'd1);

      // R10: fill to DEPTH (3 stored now, add 5)
      for (int i = 0; i < 5; i++) offer_rts(4'd7, 8'(i), 12'd1, 1, 0, '0, "R10");
      offer_rts(4'd8, 8'd8, 12'd1, 0, 0, '0, "R10");
      offer_post(4'd8, 8'd8, 16'h0800, 0, 0, '0, "R10");
      offer_post(4'd7, 8'd0, 16'h0700, 1, 1, 12'd1, "R10");
      stream(1, 16'h0700, 4'd7, 8'd0);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3/R4", "all replies seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule